// File: doc/BRIEF.md
# One-Bit Processor Cell Array

This block is a datapath of configurable width made from identical one-bit processor cells placed side by side. Each cell keeps two storage bits: an accumulator and a scratch register. Each cell also holds a small operand selector, a one-bit ALU and a one-bit shifter stage. Every cell receives the same 10-bit control word, its own bit of the external data bus, and its own bit of the output bus. Arithmetic carries pass from each cell to the next more significant cell in a plain ripple chain. Shifts move a bit between adjacent cells. Logic operations stay inside each cell.

In use, a sequencer presents one control word per clock. The result is visible on the output bus in the same cycle, and the chosen register is updated at the next rising edge. The carry out of the top cell is brought out as the carry flag. The carry into the bottom cell comes from a pin, so the caller sets it to 1 for two's-complement subtraction and negation.

Top module: `bsa_array`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the accumulator and the scratch register in every cell.
- R2: Operand select `uop[2:0]` picks the (R, S) pair as follows: 0=(A,T), 1=(D,A), 2=(D,T), 3=(0,A), 4=(0,T), 5=(D,0), 6=(A,0), 7=(A,D).
- R3: ALU code `uop[5:3]`=0 gives R+S+`cin` over the full width. The carry ripples through every cell, and `cout` is the carry out of the top bit.
- R4: Code 1 gives R+~S+`cin` and code 2 gives S+~R+`cin`. With `cin`=1 these are the exact differences R−S and S−R, and `cout`=1 means no borrow occurred.
- R5: Code 3 gives 0+~S+`cin`, which is the two's-complement negation of S when `cin`=1.
- R6: Codes 4, 5, 6 and 7 give bitwise AND, OR, XOR and XNOR of R and S. For these codes `cout` is 0 whatever `cin` is.
- R7: Destination `uop[7:6]` works as follows. 0 writes the shifter output into A. 1 writes it into T. 2 and 3 write nothing. The output `y_out` shows the ALU result F, except for code 2, where it shows A.
- R8: Shift control `uop[9:8]` works as follows. 0 passes F. 1 shifts left by one position, with `shl_in` entering bit 0. 2 shifts right by one position, with `shr_in` entering the top bit. 3 gives all zeros.
- R9: The combinational result is visible in the cycle the control word is applied. A register write becomes visible only after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| uop | input | 10 | Control word: [2:0] operands, [5:3] ALU, [7:6] destination, [9:8] shift |
| d_in | input | N_CELLS | External data, one bit per cell |
| cin | input | 1 | Carry into the least significant cell |
| shl_in | input | 1 | Serial bit entering bit 0 on a left shift |
| shr_in | input | 1 | Serial bit entering the top bit on a right shift |
| y_out | output | N_CELLS | Output bus |
| cout | output | 1 | Carry out of the most significant cell |

## Verification
The bench targets a full-length carry ripple: 0xFF plus 1 must give zero with a carry, and a broken link in the chain would leave upper bits set. Subtraction is tested with equal operands and with borrowing operands in both operand orders, so an inverted borrow flag or swapped operands would show up. The serial inputs at both ends of a shift are checked, which catches a shifter that drops the edge bit or feeds it to the wrong end. Writes to one register are checked to leave the other register unchanged, and reading A through the output shows whether a no-write code still loads A.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
   typedef enum logic [2:0] {
      SRC_AT = 3'd0, SRC_DA = 3'd1, SRC_DT = 3'd2, SRC_ZA = 3'd3,
      SRC_ZT = 3'd4, SRC_DZ = 3'd5, SRC_AZ = 3'd6, SRC_AD = 3'd7
   } src_e;

   typedef enum logic [2:0] {
      FN_ADD = 3'd0, FN_RSUB = 3'd1, FN_SSUB = 3'd2, FN_NEG = 3'd3,
      FN_AND = 3'd4, FN_OR = 3'd5, FN_XOR = 3'd6, FN_XNOR = 3'd7
   } fn_e;

   typedef enum logic [1:0] {
      DST_A = 2'd0, DST_T = 2'd1, DST_SHOWA = 2'd2, DST_NONE = 2'd3
   } dst_e;

   typedef enum logic [1:0] {
      SH_PASS = 2'd0, SH_LEFT = 2'd1, SH_RIGHT = 2'd2, SH_ZERO = 2'd3
   } sh_e;

   typedef struct packed {
      sh_e  shift;
      dst_e dest;
      fn_e  fn;
      src_e src;
   } uop_t;

   localparam int UOP_W = $bits(uop_t);
endpackage

// File: rtl/bsa_srcmux.sv
module bsa_srcmux
   import bsa_pkg::*;
(
   input  src_e src,
   input  logic d,
   input  logic a,
   input  logic t,
   output logic r,
   output logic s
);
   always_comb begin
      unique case (src)
         SRC_AT: begin r = a;    s = t;    end
         SRC_DA: begin r = d;    s = a;    end
         SRC_DT: begin r = d;    s = t;    end
         SRC_ZA: begin r = 1'b0; s = a;    end
         SRC_ZT: begin r = 1'b0; s = t;    end
         SRC_DZ: begin r = d;    s = 1'b0; end
         SRC_AZ: begin r = a;    s = 1'b0; end
         default: begin r = a;   s = d;    end
      endcase
   end
endmodule

// File: rtl/bsa_alu.sv
module bsa_alu
   import bsa_pkg::*;
(
   input  fn_e  fn,
   input  logic r,
   input  logic s,
   input  logic ci,
   output logic f,
   output logic co
);
   logic x, y;
   logic arith;

   assign arith = ~fn[2];

   // operand conditioning for the adder path
   always_comb begin
      unique case (fn)
         FN_ADD:  begin x = r;    y = s;  end
         FN_RSUB: begin x = r;    y = ~s; end
         FN_SSUB: begin x = ~r;   y = s;  end
         FN_NEG:  begin x = 1'b0; y = ~s; end
         default: begin x = r;    y = s;  end
      endcase
   end

   always_comb begin
      if (arith) begin
         f  = x ^ y ^ ci;
         co = (x & y) | (ci & (x ^ y));
      end else begin
         co = 1'b0;
         unique case (fn)
            FN_AND:  f = r & s;
            FN_OR:   f = r | s;
            FN_XOR:  f = r ^ s;
            default: f = ~(r ^ s);
         endcase
      end
   end
endmodule

// File: rtl/bsa_shifter.sv
module bsa_shifter
   import bsa_pkg::*;
(
   input  sh_e  mode,
   input  logic f_self,
   input  logic f_lower,
   input  logic f_upper,
   output logic l
);
   always_comb begin
      unique case (mode)
         SH_PASS:  l = f_self;
         SH_LEFT:  l = f_lower;
         SH_RIGHT: l = f_upper;
         default:  l = 1'b0;
      endcase
   end
endmodule

// File: rtl/bsa_cell.sv
module bsa_cell
   import bsa_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  uop_t u,
   input  logic d,
   input  logic ci,
   input  logic f_lower,
   input  logic f_upper,
   output logic co,
   output logic f,
   output logic y,
   output logic a_q,
   output logic t_q
);
   logic r, s, l;
   logic wr_a, wr_t;

   bsa_srcmux u_src (.src(u.src), .d(d), .a(a_q), .t(t_q), .r(r), .s(s));
   bsa_alu    u_alu (.fn(u.fn), .r(r), .s(s), .ci(ci), .f(f), .co(co));
   bsa_shifter u_sh (.mode(u.shift), .f_self(f), .f_lower(f_lower),
                     .f_upper(f_upper), .l(l));

   assign wr_a = (u.dest == DST_A);
   assign wr_t = (u.dest == DST_T);

   always_ff @(posedge clk) begin
      if (rst) begin
         a_q <= 1'b0;
         t_q <= 1'b0;
      end else begin
         if (wr_a) a_q <= l;
         if (wr_t) t_q <= l;
      end
   end

   assign y = (u.dest == DST_SHOWA) ? a_q : f;
endmodule

// File: rtl/bsa_array.sv
module bsa_array
   import bsa_pkg::*;
#(
   parameter int N_CELLS = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [9:0]         uop,
   input  logic [N_CELLS-1:0] d_in,
   input  logic               cin,
   input  logic               shl_in,
   input  logic               shr_in,
   output logic [N_CELLS-1:0] y_out,
   output logic               cout
);
   localparam int MSB = N_CELLS - 1;

   if (N_CELLS < 2) begin : g_bad_width
      $error("bsa_array: N_CELLS must be at least 2");
   end
   if (UOP_W != 10) begin : g_bad_uop
      $error("bsa_array: control word layout must be 10 bits");
   end

   uop_t               u;
   logic [N_CELLS:0]   carry;
   logic [N_CELLS-1:0] f_vec, a_vec, t_vec;

   assign u        = uop_t'(uop);
   assign carry[0] = cin;
   assign cout     = carry[N_CELLS];

   for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
      logic lo_in, hi_in;
      if (i == 0) begin : g_lo_edge
         assign lo_in = shl_in;
      end else begin : g_lo_link
         assign lo_in = f_vec[i-1];
      end
      if (i == MSB) begin : g_hi_edge
         assign hi_in = shr_in;
      end else begin : g_hi_link
         assign hi_in = f_vec[i+1];
      end

      bsa_cell u_cell (
         .clk(clk), .rst(rst), .u(u), .d(d_in[i]), .ci(carry[i]),
         .f_lower(lo_in), .f_upper(hi_in), .co(carry[i+1]),
         .f(f_vec[i]), .y(y_out[i]), .a_q(a_vec[i]), .t_q(t_vec[i])
      );
   end

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (a_vec == '0 && t_vec == '0)); // R1
   AST_NOWRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (u.dest == DST_SHOWA || u.dest == DST_NONE) |=> ($stable(a_vec) && $stable(t_vec))); // R7
   AST_A_WRITE_KEEPS_T: assert property (@(posedge clk) disable iff (rst)
      (u.dest == DST_A) |=> $stable(t_vec)); // R7
   AST_T_WRITE_KEEPS_A: assert property (@(posedge clk) disable iff (rst)
      (u.dest == DST_T) |=> $stable(a_vec)); // R7
   AST_SHOWA_OUTPUT: assert property (@(posedge clk) disable iff (rst)
      (u.dest == DST_SHOWA) |-> (y_out == a_vec)); // R7
   AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
      u.fn[2] |-> !cout); // R6
   AST_ZERO_SHIFT_LOAD: assert property (@(posedge clk) disable iff (rst)
      (u.shift == SH_ZERO && u.dest == DST_A) |=> (a_vec == '0)); // R8
endmodule

// File: tb/bsa_array_tb.sv
module bsa_array_tb_top;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [9:0]   uop = '0;
   logic [W-1:0] d_in = '0;
   logic         cin = 1'b0, shl_in = 1'b0, shr_in = 1'b0;
   logic [W-1:0] y_out;
   logic         cout;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [W-1:0] ma = '0, mt = '0;

   always #2 clk = ~clk;

   bsa_array #(.N_CELLS(W)) dut_i (
      .clk(clk), .rst(rst), .uop(uop), .d_in(d_in), .cin(cin),
      .shl_in(shl_in), .shr_in(shr_in), .y_out(y_out), .cout(cout)
   );

   function automatic logic [9:0] mk(int src, int fn, int dst, int sh);
      return {sh[1:0], dst[1:0], fn[2:0], src[2:0]};
   endfunction

   task automatic step(input logic [9:0] op, input logic [W-1:0] d,
                       input logic c, input logic sl, input logic sr,
                       input logic do_rst, input string tag);
      logic [W-1:0] r, s, f, l, ey;
      logic [W:0]   sum;
      logic         eco;
      uop = op; d_in = d; cin = c; shl_in = sl; shr_in = sr; rst = do_rst;
      case (op[2:0])
         3'd0: begin r = ma; s = mt; end
         3'd1: begin r = d;  s = ma; end
         3'd2: begin r = d;  s = mt; end
         3'd3: begin r = '0; s = ma; end
         3'd4: begin r = '0; s = mt; end
         3'd5: begin r = d;  s = '0; end
         3'd6: begin r = ma; s = '0; end
         default: begin r = ma; s = d; end
      endcase
      eco = 1'b0;
      case (op[5:3])
         3'd0: begin sum = {1'b0, r} + {1'b0, s} + c;  f = sum[W-1:0]; eco = sum[W]; end
         3'd1: begin sum = {1'b0, r} + {1'b0, ~s} + c; f = sum[W-1:0]; eco = sum[W]; end
         3'd2: begin sum = {1'b0, ~r} + {1'b0, s} + c; f = sum[W-1:0]; eco = sum[W]; end
         3'd3: begin sum = {1'b0, ~s} + c;             f = sum[W-1:0]; eco = sum[W]; end
         3'd4: f = r & s;
         3'd5: f = r | s;
         3'd6: f = r ^ s;
         default: f = ~(r ^ s);
      endcase
      case (op[9:8])
         2'd0: l = f;
         2'd1: l = {f[W-2:0], sl};
         2'd2: l = {sr, f[W-1:1]};
         default: l = '0;
      endcase
      ey = (op[7:6] == 2'd2) ? ma : f;
      #1;
      checks++;
      if (y_out !== ey || cout !== eco) begin
         failures++;
         $display("FAIL %s: y=%h exp=%h cout=%b exp=%b", tag, y_out, ey, cout, eco);
      end
      @(posedge clk);
      if (do_rst) begin ma = '0; mt = '0; end
      else if (op[7:6] == 2'd0) ma = l;
      else if (op[7:6] == 2'd1) mt = l;
      #1;
   endtask

   // helpers built on step; readbacks check registers at the ports
   task automatic load_a(input logic [W-1:0] v, input string tag);
      step(mk(5, 0, 0, 0), v, 1'b0, 1'b0, 1'b0, 1'b0, tag);
   endtask
   task automatic load_t(input logic [W-1:0] v, input string tag);
      step(mk(5, 0, 1, 0), v, 1'b0, 1'b0, 1'b0, 1'b0, tag);
   endtask
   task automatic read_a(input string tag);
      step(mk(0, 0, 2, 0), '0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
   endtask
   task automatic read_t(input string tag);
      step(mk(4, 0, 3, 0), '0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
   endtask

   task automatic t_reset;
      step(mk(0, 0, 3, 0), '0, 1'b0, 1'b0, 1'b0, 1'b1, "R1 reset");
      read_a("R1 A after reset");
      read_t("R1 T after reset");
      load_a(8'h5A, "R9 load A");
      load_t(8'hC3, "R9 load T");
      read_a("R9 A visible after edge");
      step(mk(0, 0, 3, 0), '0, 1'b0, 1'b0, 1'b0, 1'b1, "R1 reset again");
      read_a("R1 A cleared");
      read_t("R1 T cleared");
   endtask

   task automatic t_src;
      load_a(8'h21, "R2 setup A");
      load_t(8'h40, "R2 setup T");
      for (int k = 0; k < 8; k++)
         step(mk(k, 0, 3, 0), 8'h06, 1'b0, 1'b0, 1'b0, 1'b0, "R2 operand select");
   endtask

   task automatic t_add;
      load_a(8'hFF, "R3 setup");
      step(mk(1, 0, 3, 0), 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, "R3 full ripple FF+1");
      step(mk(3, 0, 3, 0), 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R3 cin ripple 0+FF+1");
      load_a(8'h7F, "R3 setup");
      step(mk(1, 0, 3, 0), 8'h01, 1'b1, 1'b0, 1'b0, 1'b0, "R3 7F+1+cin");
      step(mk(1, 0, 3, 0), 8'h80, 1'b0, 1'b0, 1'b0, 1'b0, "R3 no carry");
   endtask

   task automatic t_sub;
      load_a(8'h30, "R4 setup");
      step(mk(1, 1, 3, 0), 8'h50, 1'b1, 1'b0, 1'b0, 1'b0, "R4 R-S no borrow");
      step(mk(1, 1, 3, 0), 8'h10, 1'b1, 1'b0, 1'b0, 1'b0, "R4 R-S borrow");
      step(mk(1, 1, 3, 0), 8'h30, 1'b1, 1'b0, 1'b0, 1'b0, "R4 R-S equal");
      step(mk(1, 2, 3, 0), 8'h50, 1'b1, 1'b0, 1'b0, 1'b0, "R4 S-R borrow");
      step(mk(1, 2, 3, 0), 8'h10, 1'b1, 1'b0, 1'b0, 1'b0, "R4 S-R no borrow");
   endtask

   task automatic t_neg;
      load_a(8'h01, "R5 setup");
      step(mk(3, 3, 3, 0), '0, 1'b1, 1'b0, 1'b0, 1'b0, "R5 negate 1");
      load_a(8'h00, "R5 setup");
      step(mk(3, 3, 3, 0), '0, 1'b1, 1'b0, 1'b0, 1'b0, "R5 negate 0");
      step(mk(3, 3, 3, 0), '0, 1'b0, 1'b0, 1'b0, 1'b0, "R5 complement");
   endtask

   task automatic t_logic;
      load_a(8'hCC, "R6 setup");
      for (int k = 4; k < 8; k++)
         step(mk(1, k, 3, 0), 8'hAA, 1'b1, 1'b0, 1'b0, 1'b0, "R6 logic op");
   endtask

   task automatic t_dest;
      load_a(8'h11, "R7 setup A");
      load_t(8'h22, "R7 T write");
      read_a("R7 A kept on T write");
      step(mk(5, 0, 3, 0), 8'h99, 1'b0, 1'b0, 1'b0, 1'b0, "R7 code 3 no write");
      step(mk(5, 0, 2, 0), 8'h77, 1'b0, 1'b0, 1'b0, 1'b0, "R7 code 2 shows A");
      read_a("R7 A unchanged");
      read_t("R7 T unchanged");
      load_a(8'h44, "R7 A write");
      read_t("R7 T kept on A write");
   endtask

   task automatic t_shift;
      step(mk(5, 0, 0, 1), 8'h81, 1'b0, 1'b1, 1'b0, 1'b0, "R8 left shift");
      read_a("R8 left result with shl_in");
      step(mk(5, 0, 0, 2), 8'h81, 1'b0, 1'b0, 1'b1, 1'b0, "R8 right shift");
      read_a("R8 right result with shr_in");
      step(mk(5, 0, 1, 1), 8'h40, 1'b0, 1'b0, 1'b0, 1'b0, "R8 left into T");
      read_t("R8 T left result");
      step(mk(5, 0, 0, 3), 8'hFF, 1'b0, 1'b1, 1'b1, 1'b0, "R8 zero");
      read_a("R8 zero result");
      step(mk(5, 0, 0, 0), 8'h3C, 1'b0, 1'b1, 1'b1, 1'b0, "R8 pass");
      read_a("R8 pass result");
   endtask

   initial begin
      #800000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run hung, elapsed=%0t expected completion", $time);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      @(posedge clk); #1;
      @(posedge clk); #1;
      t_reset();
      t_src();
      t_add();
      t_sub();
      t_neg();
      t_logic();
      t_dest();
      t_shift();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule